// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It decides whether to keep or discard an incoming frame, using only the frame's 48-bit destination address. The parser upstream presents that address together with a one-cycle strobe. One clock later the filter returns a registered verdict. The verdict has an accept bit and one flag for each reason a frame can match: the station (unicast) address, an entry in a small multicast table, the all-ones broadcast address, or promiscuous mode.

Configuration arrives as 32-bit word writes on a simple write port. A selector picks the target of each write.

- The station address is written as a low word and a high word.
- A multicast address is written the same way. Its low word goes into a staging register, and the write of its high word commits the entry. The high word also carries the entry index.
- A mode word carries the promiscuous control. While it is set, every frame is accepted.
- Writing an all-zero address to a multicast entry empties that entry.

Top module: `afilt_top`

## Requirements
- R1: After reset, dec_valid is low, every multicast entry is empty and promiscuous mode is off. A probe of a non-broadcast address other than the station address is therefore dropped.
- R2: The station address is written in two parts. A write with selector 0 loads address bytes 0..3, with byte k taken from cfg_wdata[8k+7:8k]. A write with selector 1 loads byte 4 from bits 7:0 and byte 5 from bits 15:8. On rx_dest, byte k lies in bits 8k+7:8k. An exact match gives dec_station=1 and dec_accept=1. Any difference in any byte gives dec_station=0.
- R3: A write with selector 2 stages bytes 0..3 of a multicast address. A write with selector 3 supplies bytes 4 and 5 in bits 15:0 and the entry index in bits 17:16. That write stores the staged and supplied bytes into the indexed entry and marks the entry valid when the address is nonzero. A probe of any valid entry's address gives dec_group=1 and dec_accept=1.
- R4: Committing an all-zero address to an entry leaves that entry invalid. The address the entry held before is then no longer matched by it.
- R5: Bit 0 of a write with selector 4 is the promiscuous control. While it is 1, every probe gives dec_promisc=1 and dec_accept=1. Writing it back to 0 restores normal filtering.
- R6: The destination FF:FF:FF:FF:FF:FF always gives dec_bcast=1 and dec_accept=1.
- R7: The verdict is registered. dec_valid is high in exactly the cycle after a cycle with rx_valid high. While dec_valid is low, every flag and dec_accept are low.
- R8: Writes with selectors 5, 6 or 7 change nothing. A staging write (selector 2) on its own does not change any multicast entry.
- R9: dec_accept is the OR of the four match flags. For any mix of configuration and addresses, the verdict equals that of an independent model of R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target of the write (0 station low, 1 station high, 2 group stage, 3 group commit, 4 mode) |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | Destination address strobe |
| rx_dest | input | 48 | Destination address, byte k in bits 8k+7:8k |
| dec_valid | output | 1 | Verdict valid, one cycle after rx_valid |
| dec_accept | output | 1 | Frame accepted |
| dec_station | output | 1 | Matched the station address |
| dec_group | output | 1 | Matched a valid multicast entry |
| dec_bcast | output | 1 | Destination was broadcast |
| dec_promisc | output | 1 | Promiscuous mode was on |

## Verification
The properties compare a probe with the station address and the mode bit as they stood at the sampling edge. This assumes that a configuration write and a probe in the same cycle are judged against the table contents from before the write. The stimulus never issues a write and a probe together, so that ordering is never the only thing deciding a result. The random part draws its addresses partly from the configured station and table entries and partly from broadcast. This keeps every match path active rather than relying on chance hits in a 48-bit space.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

   localparam int MAC_W  = 48;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      SEL_STA_LO = 3'd0,
      SEL_STA_HI = 3'd1,
      SEL_GRP_LO = 3'd2,
      SEL_GRP_HI = 3'd3,
      SEL_MODE   = 3'd4
   } cfg_sel_e;

   typedef struct packed {
      logic valid;
      logic accept;
      logic station;
      logic group;
      logic bcast;
      logic promisc;
   } verdict_t;

endpackage

// File: rtl/afilt_station.sv
module afilt_station
   import afilt_pkg::*;
#(
   parameter int ADDR_W = MAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [31:0]       lo_word,
   input  logic [15:0]       hi_half,
   input  logic [ADDR_W-1:0] lookup,
   output logic [ADDR_W-1:0] station_addr,
   output logic              hit
);
   localparam int HI_W = ADDR_W - 32;

   logic [31:0]     lo_q;
   logic [HI_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (we_lo) lo_q <= lo_word;
         if (we_hi) hi_q <= hi_half[HI_W-1:0];
      end
   end

   assign station_addr = {hi_q, lo_q};
   assign hit          = (station_addr == lookup);

endmodule

// File: rtl/afilt_cam.sv
module afilt_cam
   import afilt_pkg::*;
#(
   parameter int ADDR_W = MAC_W,
   parameter int DEPTH  = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_stage,
   input  logic              we_commit,
   input  logic [31:0]       stage_word,
   input  logic [15:0]       commit_half,
   input  logic [IDX_W-1:0]  commit_idx,
   input  logic [ADDR_W-1:0] lookup,
   output logic [DEPTH-1:0]  entry_valid,
   output logic              hit
);
   logic [31:0]       stage_q;
   logic [ADDR_W-1:0] new_addr;
   logic              new_nonzero;
   logic [DEPTH-1:0]  match_vec;

   always_ff @(posedge clk) begin
      if (!rst_n)        stage_q <= '0;
      else if (we_stage) stage_q <= stage_word;
   end

   assign new_addr    = {commit_half[ADDR_W-33:0], stage_q};
   assign new_nonzero = |new_addr;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic [ADDR_W-1:0] addr_q;
      logic              vld_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
         end else if (we_commit && (commit_idx == IDX_W'(e))) begin
            addr_q <= new_addr;
            vld_q  <= new_nonzero;
         end
      end

      assign match_vec[e]   = vld_q && (addr_q == lookup);
      assign entry_valid[e] = vld_q;
   end

   assign hit = |match_vec;

endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
   import afilt_pkg::*;
#(
   parameter bit BCAST_EN = 1'b1,
   parameter int ADDR_W   = MAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [ADDR_W-1:0] lookup,
   input  logic              station_hit,
   input  logic              group_hit,
   input  logic              promisc_on,
   output verdict_t          verdict
);
   logic bcast_hit;

   if (BCAST_EN) begin : g_bcast
      assign bcast_hit = &lookup;
   end else begin : g_no_bcast
      assign bcast_hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict <= '0;
      end else if (strobe) begin
         verdict.valid   <= 1'b1;
         verdict.station <= station_hit;
         verdict.group   <= group_hit;
         verdict.bcast   <= bcast_hit;
         verdict.promisc <= promisc_on;
         verdict.accept  <= station_hit | group_hit | bcast_hit | promisc_on;
      end else begin
         verdict <= '0;
      end
   end

endmodule

// File: rtl/afilt_top.sv
module afilt_top
   import afilt_pkg::*;
#(
   parameter int CAM_DEPTH   = 4,
   parameter int IDX_LSB     = 16,
   parameter int PROMISC_BIT = 0,
   parameter bit BCAST_EN    = 1'b1,
   localparam int IDX_W      = (CAM_DEPTH > 1) ? $clog2(CAM_DEPTH) : 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        rx_valid,
   input  logic [47:0] rx_dest,
   output logic        dec_valid,
   output logic        dec_accept,
   output logic        dec_station,
   output logic        dec_group,
   output logic        dec_bcast,
   output logic        dec_promisc
);
   if (CAM_DEPTH < 1 || CAM_DEPTH > 64) begin : g_bad_depth
      $error("afilt_top: CAM_DEPTH must lie in 1..64");
   end
   if (IDX_LSB < 16 || IDX_LSB + IDX_W > 32) begin : g_bad_idx
      $error("afilt_top: index field must sit above bit 15 inside the word");
   end
   if (PROMISC_BIT < 0 || PROMISC_BIT > 31) begin : g_bad_pbit
      $error("afilt_top: PROMISC_BIT out of word");
   end

   logic [MAC_W-1:0]     station_addr;
   logic                 station_hit;
   logic                 group_hit;
   logic [CAM_DEPTH-1:0] entry_valid;
   logic                 promisc_on;
   verdict_t             verdict;

   logic wr_sta_lo, wr_sta_hi, wr_grp_lo, wr_grp_hi, wr_mode;

   always_comb begin
      wr_sta_lo = 1'b0;
      wr_sta_hi = 1'b0;
      wr_grp_lo = 1'b0;
      wr_grp_hi = 1'b0;
      wr_mode   = 1'b0;
      if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            SEL_STA_LO: wr_sta_lo = 1'b1;
            SEL_STA_HI: wr_sta_hi = 1'b1;
            SEL_GRP_LO: wr_grp_lo = 1'b1;
            SEL_GRP_HI: wr_grp_hi = 1'b1;
            SEL_MODE:   wr_mode   = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       promisc_on <= 1'b0;
      else if (wr_mode) promisc_on <= cfg_wdata[PROMISC_BIT];
   end

   afilt_station #(.ADDR_W(MAC_W)) u_station (
      .clk          (clk),
      .rst_n        (rst_n),
      .we_lo        (wr_sta_lo),
      .we_hi        (wr_sta_hi),
      .lo_word      (cfg_wdata),
      .hi_half      (cfg_wdata[15:0]),
      .lookup       (rx_dest),
      .station_addr (station_addr),
      .hit          (station_hit)
   );

   afilt_cam #(.ADDR_W(MAC_W), .DEPTH(CAM_DEPTH)) u_cam (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_stage    (wr_grp_lo),
      .we_commit   (wr_grp_hi),
      .stage_word  (cfg_wdata),
      .commit_half (cfg_wdata[15:0]),
      .commit_idx  (cfg_wdata[IDX_LSB +: IDX_W]),
      .lookup      (rx_dest),
      .entry_valid (entry_valid),
      .hit         (group_hit)
   );

   afilt_decide #(.BCAST_EN(BCAST_EN), .ADDR_W(MAC_W)) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (rx_valid),
      .lookup      (rx_dest),
      .station_hit (station_hit),
      .group_hit   (group_hit),
      .promisc_on  (promisc_on),
      .verdict     (verdict)
   );

   assign dec_valid   = verdict.valid;
   assign dec_accept  = verdict.accept;
   assign dec_station = verdict.station;
   assign dec_group   = verdict.group;
   assign dec_bcast   = verdict.bcast;
   assign dec_promisc = verdict.promisc;

endmodule

// File: rtl/afilt_checks.sv
module afilt_checks #(
   parameter bit BCAST_EN = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic [47:0] rx_dest,
   input logic [47:0] station_addr,
   input logic        promisc_on,
   input logic        dec_valid,
   input logic        dec_accept,
   input logic        dec_station,
   input logic        dec_group,
   input logic        dec_bcast,
   input logic        dec_promisc
);
   assert_strobe_to_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> dec_valid);

   assert_no_strobe_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !dec_valid);

   assert_quiet_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !(dec_accept | dec_station | dec_group | dec_bcast | dec_promisc));

   assert_station_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_dest == station_addr) |=> (dec_station && dec_accept));

   assert_promisc_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && promisc_on) |=> (dec_promisc && dec_accept));

   assert_broadcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && BCAST_EN && (&rx_dest)) |=> (dec_bcast && dec_accept));

   assert_drop_means_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> !(dec_station || dec_group || dec_bcast || dec_promisc));

endmodule

bind afilt_top afilt_checks #(.BCAST_EN(BCAST_EN)) u_checks (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_valid     (rx_valid),
   .rx_dest      (rx_dest),
   .station_addr (station_addr),
   .promisc_on   (promisc_on),
   .dec_valid    (dec_valid),
   .dec_accept   (dec_accept),
   .dec_station  (dec_station),
   .dec_group    (dec_group),
   .dec_bcast    (dec_bcast),
   .dec_promisc  (dec_promisc)
);

// File: tb/tb_afilt_top.sv
module tb_afilt_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        rx_valid = 1'b0;
   logic [47:0] rx_dest = '0;
   logic dec_valid, dec_accept, dec_station, dec_group, dec_bcast, dec_promisc;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model
   logic [47:0] m_sta = '0;
   logic [31:0] m_stage = '0;
   logic [47:0] m_cam [4];
   logic        m_cv  [4];
   logic        m_prom = 1'b0;

   always #2.5 clk = ~clk;

   afilt_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_dest(rx_dest),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_station(dec_station),
      .dec_group(dec_group), .dec_bcast(dec_bcast), .dec_promisc(dec_promisc)
   );

   task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   function automatic logic [5:0] model(input logic [47:0] d);
      logic st, gr, bc;
      st = (d == m_sta);
      gr = 1'b0;
      for (int i = 0; i < 4; i++) if (m_cv[i] && m_cam[i] == d) gr = 1'b1;
      bc = &d;
      return {1'b1, st | gr | bc | m_prom, st, gr, bc, m_prom};
   endfunction

   task automatic cfgw(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      case (sel)
         3'd0: m_sta[31:0] = data;
         3'd1: m_sta[47:32] = data[15:0];
         3'd2: m_stage = data;
         3'd3: begin
            m_cam[data[17:16]] = {data[15:0], m_stage};
            m_cv[data[17:16]]  = |{data[15:0], m_stage};
         end
         3'd4: m_prom = data[0];
         default: ;
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_group(input int idx, input logic [47:0] a);
      cfgw(3'd2, a[31:0]);
      cfgw(3'd3, {14'd0, 2'(idx), a[47:32]});
   endtask

   task automatic probe(input string req, input logic [47:0] d);
      logic [5:0] exp;
      @(negedge clk);
      exp = model(d);
      rx_valid = 1'b1; rx_dest = d;
      @(negedge clk);
      rx_valid = 1'b0;
      check(req, {dec_valid, dec_accept, dec_station, dec_group, dec_bcast, dec_promisc}, exp);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [47:0] d;
      logic [47:0] pool [6];
      int unsigned r;
      for (int i = 0; i < 4; i++) begin m_cam[i] = '0; m_cv[i] = 1'b0; end
      void'($urandom(32'd1357));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", {dec_valid, dec_accept, dec_station, dec_group, dec_bcast, dec_promisc}, 6'b0);
      probe("R1", 48'h0100_005E_0001);

      // R2 station address
      cfgw(3'd0, 32'h33_22_11_00 | 32'h4400_0000);
      cfgw(3'd1, 32'hABCD_5566);
      probe("R2", 48'h5566_4422_1100 | 48'h0000_0033_0000);
      probe("R2", m_sta);
      probe("R2", m_sta ^ 48'h0100_0000_0000);
      probe("R2", m_sta ^ 48'h0000_0000_0080);

      // R3 multicast entries
      set_group(0, 48'h0100_5E00_0001);
      set_group(1, 48'h0200_5E00_0033);
      set_group(2, 48'hFEDC_BA98_7603);
      set_group(3, 48'h0000_0000_0001);
      for (int i = 0; i < 4; i++) probe("R3", m_cam[i]);
      probe("R3", 48'h0100_5E00_0002);

      // R8 ignored selectors and staging alone
      cfgw(3'd5, 32'hFFFF_FFFF);
      cfgw(3'd6, 32'h0000_0000);
      cfgw(3'd7, 32'h1234_5678);
      probe("R8", m_sta);
      cfgw(3'd2, 32'h0BAD_F00D);
      probe("R8", m_cam[1]);
      probe("R8", {16'h0001, 32'h0BAD_F00D});

      // R6 broadcast
      probe("R6", 48'hFFFF_FFFF_FFFF);

      // R5 promiscuous
      cfgw(3'd4, 32'h1);
      probe("R5", 48'h0123_4567_89AB);
      probe("R5", 48'h0);
      cfgw(3'd4, 32'h0);
      probe("R5", 48'h0123_4567_89AB);

      // R4 clearing an entry
      d = m_cam[2];
      set_group(2, 48'h0);
      probe("R4", d);
      probe("R4", m_cam[0]);

      // R7 no strobe -> quiet outputs
      @(negedge clk);
      check("R7", {dec_valid, dec_accept, dec_station, dec_group, dec_bcast, dec_promisc}, 6'b0);

      // R9 random cross-check
      for (int n = 0; n < 600; n++) begin
         r = $urandom % 100;
         if (r < 6) begin
            set_group($urandom % 4, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
         end else if (r < 8) begin
            cfgw(3'd4, {31'd0, ($urandom % 4) == 0});
         end else if (r < 9) begin
            cfgw(3'd0, $urandom);
         end else if (r < 10) begin
            set_group($urandom % 4, 48'h0);
         end
         pool[0] = m_sta; pool[1] = m_cam[0]; pool[2] = m_cam[1];
         pool[3] = m_cam[2]; pool[4] = m_cam[3]; pool[5] = 48'hFFFF_FFFF_FFFF;
         r = $urandom % 10;
         if (r < 6) d = pool[r];
         else d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         probe("R9", d);
         if (n % 50 == 0) begin
            @(negedge clk);
            check("R7", {dec_valid, dec_accept, dec_station, dec_group, dec_bcast, dec_promisc}, 6'b0);
         end
      end

      summary();
   end
endmodule